// File: doc/BRIEF.md
# Four-Level Grouped Priority Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of fourteen interrupt sources is served next. Seven sources are external pins and the rest come from on-chip peripheral flags. Every source has its own enable bit, and a global enable gates all of them. Each source belongs to one of six priority groups, and each group is given one of four levels. The level is formed from one bit in each of two priority registers.

All request inputs are sampled once per machine cycle, on the `mcStrobe` pulse. Edge-triggered requests are latched in a pending flag. Level-triggered requests are followed as they are and not latched. The winner of the arbitration is presented as a fixed vector address. That address is held until the core acknowledges it, and the acknowledge pushes the winner's level onto a four-bit in-service record. A request may interrupt a running handler only when its level is strictly above the highest level in service. A return strobe from the core retires the highest level in service.

Top module: `irq_group_arbiter`

## Requirements
- R1: Source index s (0 to 13) has a fixed vector: s=0..5 give 0003h+8*s, s=6..11 give 0043h+8*(s-6), s=12 gives 0083h, s=13 gives 009Bh. The sources, by index, are:
  - 0 ext0 (`extPin[0]`), 1 timer0 (`periphFlag[0]`), 2 ext1 (`extPin[1]`), 3 timer1 (`periphFlag[1]`)
  - 4 serial0, 5 timer2, 6 ADC (`periphFlag[6]`)
  - 7..11 ext2..ext6 (`extPin[2..6]`), 12 serial1, 13 compare-timer overflow (`periphFlag[9]`)
- R2: `enData[s]` enables source s. A source whose enable bit is 0 never produces a vector. A write takes effect on the clock where `enWe` is high.
- R3: `enData[14]` is the global enable. While it is 0 no vector is produced, but edge flags already pending stay set and are served once it is set.
- R4: `extMode[0]` controls ext0 and `extMode[1]` controls ext1. The value 1 selects falling-edge triggering and 0 selects low-level triggering. A low-level request is not latched: it is raised again after the return for as long as the pin stays low.
- R5: `extMode[2]` controls ext2 and `extMode[3]` controls ext3. The value 1 selects rising edges and 0 selects falling edges; an edge of the other direction is ignored. Ext4 to ext6 trigger on rising edges. An edge flag is cleared when its vector is acknowledged.
- R6: Sources are grouped as follows, giving each group's level = {`prio1Data[g]`, `prio0Data[g]`}, from 0 to 3:
  - group 0: {ext0, ADC}
  - group 1: {timer0, ext2}
  - group 2: {ext1, ext3}
  - group 3: {timer1, ext4}
  - group 4: {serial0, ext5, serial1}
  - group 5: {timer2, ext6, compare}
- R7: Among the eligible requests the highest level wins. Equal levels are resolved in favour of the lowest source index, which is also the lowest vector.
- R8: A request is eligible only when its level is strictly above the highest level in service, or when nothing is in service. `retStrobe` clears the highest level in service.
- R9: Inputs are sampled only on `mcStrobe`. For an eligible request with no vector outstanding, `vecValid` rises at the fourth strobe after the input changes, which is more than three machine cycles later.
- R10: After reset `vecValid` is 0. Once set, it stays high with a stable `vecAddr` until `vecAck`, and it is low on the clock after the acknowledge.
- R11: The serial0 request is `periphFlag[2]` OR `periphFlag[3]`. The timer2 request is `periphFlag[4]` OR `periphFlag[5]`. The serial1 request is `periphFlag[7]` OR `periphFlag[8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mcStrobe | input | 1 | One-clock pulse per machine cycle |
| extPin | input | 7 | External request pins ext0..ext6 |
| periphFlag | input | 10 | Peripheral request flags (see R1, R11) |
| extMode | input | 4 | Trigger mode bits for ext0..ext3 |
| enWe | input | 1 | Write strobe for the enable register |
| enData | input | 15 | Per-source enables; bit 14 is the global enable |
| prioWe | input | 1 | Write strobe for both priority registers |
| prio0Data | input | 6 | Low level bit, one per group |
| prio1Data | input | 6 | High level bit, one per group |
| vecAck | input | 1 | Core accepts the presented vector |
| retStrobe | input | 1 | Core returns from the current handler |
| vecValid | output | 1 | A vector is being presented |
| vecAddr | output | 16 | Vector address of the winner |

## Verification
Each source is raised alone in turn. This separates the vector table from the arbitration, and it exposes any mix-up among the OR-combined flags. Simultaneous pairs are raised at equal levels, then at levels set through only one group member, and then at levels that need both priority bits. These patterns tell the index tie-break apart from the group mapping and from the two-bit level encoding. Held pins, short pulses and opposite-direction edges are used to distinguish latched edge requests from followed level requests. Nested sequences with acknowledges and returns show the strict-greater preemption rule and the retirement of only the top in-service level.

// File: rtl/irqgrp_pkg.sv
package irqgrp_pkg;
  localparam int NUM_SRC   = 14;
  localparam int NUM_GRP   = 6;
  localparam int NUM_LVL   = 4;
  localparam int LVL_W     = $clog2(NUM_LVL);
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int VEC_W     = 16;
  localparam int NUM_EXT   = 7;
  localparam int NUM_PFLAG = 10;
  localparam int NUM_MODE  = 4;

  // source indices with special trigger handling
  localparam int IX_EXT0 = 0;
  localparam int IX_EXT1 = 2;
  localparam int IX_EXT2 = 7;
  localparam int IX_EXT3 = 8;
  localparam int IX_EXT4 = 9;
  localparam int IX_EXT6 = 11;

  // strobes from control to datapath
  typedef struct packed {
    logic             clrEn;
    logic [IDX_W-1:0] clrIdx;
  } dpStrobe_t;

  function automatic int srcGroup(input int s);
    return (s < 2 * NUM_GRP) ? (s % NUM_GRP) : (s - 8);
  endfunction

  function automatic logic [VEC_W-1:0] srcVector(input int s);
    if (s < 6)       return VEC_W'(16'h0003 + 8 * s);
    else if (s < 12) return VEC_W'(16'h0043 + 8 * (s - 6));
    else if (s == 12) return VEC_W'(16'h0083);
    else              return VEC_W'(16'h009B);
  endfunction
endpackage

// File: rtl/irqgrp_datapath.sv
module irqgrp_datapath
  import irqgrp_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             mcStrobe,
  input  logic [NUM_EXT-1:0]               extPin,
  input  logic [NUM_PFLAG-1:0]             periphFlag,
  input  logic [NUM_MODE-1:0]              extMode,
  input  logic                             enWe,
  input  logic [NUM_SRC:0]                 enData,
  input  logic                             prioWe,
  input  logic [NUM_GRP-1:0]               prio0Data,
  input  logic [NUM_GRP-1:0]               prio1Data,
  input  dpStrobe_t                        stb,
  output logic [NUM_SRC-1:0]               reqQ,
  output logic [NUM_SRC-1:0][LVL_W-1:0]    srcLvl
);
  localparam logic [NUM_SRC-1:0] IDLE_HIGH = NUM_SRC'((1 << IX_EXT0) | (1 << IX_EXT1));

  logic [NUM_SRC-1:0] rawSrc, smpReg, prvReg;
  logic [NUM_SRC:0]   enReg;
  logic [NUM_GRP-1:0] prio0Reg, prio1Reg;

  always_comb begin
    rawSrc     = '0;
    rawSrc[0]  = extPin[0];
    rawSrc[1]  = periphFlag[0];
    rawSrc[2]  = extPin[1];
    rawSrc[3]  = periphFlag[1];
    rawSrc[4]  = periphFlag[2] | periphFlag[3];
    rawSrc[5]  = periphFlag[4] | periphFlag[5];
    rawSrc[6]  = periphFlag[6];
    rawSrc[11:7] = extPin[6:2];
    rawSrc[12] = periphFlag[7] | periphFlag[8];
    rawSrc[13] = periphFlag[9];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      smpReg <= IDLE_HIGH;
      prvReg <= IDLE_HIGH;
    end else if (mcStrobe) begin
      smpReg <= rawSrc;
      prvReg <= smpReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg    <= '0;
      prio0Reg <= '0;
      prio1Reg <= '0;
    end else begin
      if (enWe) enReg <= enData;
      if (prioWe) begin
        prio0Reg <= prio0Data;
        prio1Reg <= prio1Data;
      end
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int GRP = srcGroup(i);
    logic edgeMode, riseMode, actLow, seen, flagReg, rawReq;

    if (i == IX_EXT0 || i == IX_EXT1) begin : g_lowsel
      assign edgeMode = extMode[i / 2];
      assign riseMode = 1'b0;
      assign actLow   = 1'b1;
    end else if (i == IX_EXT2 || i == IX_EXT3) begin : g_dirsel
      assign edgeMode = 1'b1;
      assign riseMode = extMode[i - 5];
      assign actLow   = 1'b0;
    end else if (i >= IX_EXT4 && i <= IX_EXT6) begin : g_rise
      assign edgeMode = 1'b1;
      assign riseMode = 1'b1;
      assign actLow   = 1'b0;
    end else begin : g_lvl
      assign edgeMode = 1'b0;
      assign riseMode = 1'b0;
      assign actLow   = 1'b0;
    end

    assign seen = riseMode ? (~prvReg[i] & smpReg[i]) : (prvReg[i] & ~smpReg[i]);

    always_ff @(posedge clk) begin
      if (!rstN)                                 flagReg <= 1'b0;
      else if (mcStrobe && edgeMode && seen)     flagReg <= 1'b1;
      else if ((stb.clrEn && stb.clrIdx == IDX_W'(i)) || !edgeMode)
                                                 flagReg <= 1'b0;
    end

    assign rawReq    = edgeMode ? flagReg : (prvReg[i] ^ actLow);
    assign reqQ[i]   = rawReq & enReg[i] & enReg[NUM_SRC];
    assign srcLvl[i] = {prio1Reg[GRP], prio0Reg[GRP]};
  end
endmodule

// File: rtl/irqgrp_control.sv
module irqgrp_control
  import irqgrp_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          mcStrobe,
  input  logic [NUM_SRC-1:0]            reqQ,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] srcLvl,
  input  logic                          vecAck,
  input  logic                          retStrobe,
  output dpStrobe_t                     stb,
  output logic                          vecValid,
  output logic [VEC_W-1:0]              vecAddr
);
  logic [NUM_LVL-1:0] inSvc, topMask, inSvcNext;
  logic [LVL_W-1:0]   topLvl, winLvl, vecLvl;
  logic               anyAct, winFound, pollValid, issue, ackDone;
  logic [IDX_W-1:0]   winIdx, pollIdx, vecIdx;
  logic [NUM_SRC-1:0] elig;

  always_comb begin
    anyAct  = |inSvc;
    topLvl  = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (inSvc[l]) topLvl = LVL_W'(l);
    topMask = '0;
    topMask[topLvl] = anyAct;
  end

  always_comb begin
    winFound = 1'b0;
    winIdx   = '0;
    winLvl   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      elig[i] = reqQ[i] && (!anyAct || srcLvl[i] > topLvl);
      if (elig[i] && (!winFound || srcLvl[i] > winLvl)) begin
        winFound = 1'b1;
        winIdx   = IDX_W'(i);
        winLvl   = srcLvl[i];
      end
    end
  end

  assign issue   = mcStrobe && !vecValid && pollValid && elig[pollIdx];
  assign ackDone = vecValid && vecAck;

  always_comb begin
    inSvcNext = retStrobe ? (inSvc & ~topMask) : inSvc;
    if (ackDone) inSvcNext[vecLvl] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pollValid <= 1'b0;
      pollIdx   <= '0;
      vecValid  <= 1'b0;
      vecAddr   <= '0;
      vecIdx    <= '0;
      vecLvl    <= '0;
      inSvc     <= '0;
    end else begin
      inSvc <= inSvcNext;
      if (mcStrobe) begin
        pollValid <= winFound;
        pollIdx   <= winIdx;
      end
      if (issue) begin
        vecValid <= 1'b1;
        vecAddr  <= srcVector(int'(pollIdx));
        vecIdx   <= pollIdx;
        vecLvl   <= srcLvl[pollIdx];
      end else if (ackDone) begin
        vecValid <= 1'b0;
      end
    end
  end

  assign stb.clrEn  = ackDone;
  assign stb.clrIdx = vecIdx;
endmodule

// File: rtl/irq_group_arbiter.sv
module irq_group_arbiter
  import irqgrp_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 mcStrobe,
  input  logic [NUM_EXT-1:0]   extPin,
  input  logic [NUM_PFLAG-1:0] periphFlag,
  input  logic [NUM_MODE-1:0]  extMode,
  input  logic                 enWe,
  input  logic [NUM_SRC:0]     enData,
  input  logic                 prioWe,
  input  logic [NUM_GRP-1:0]   prio0Data,
  input  logic [NUM_GRP-1:0]   prio1Data,
  input  logic                 vecAck,
  input  logic                 retStrobe,
  output logic                 vecValid,
  output logic [VEC_W-1:0]     vecAddr
);
  dpStrobe_t                     stb;
  logic [NUM_SRC-1:0]            reqQ;
  logic [NUM_SRC-1:0][LVL_W-1:0] srcLvl;

  irqgrp_datapath u_dp (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe),
    .extPin(extPin), .periphFlag(periphFlag), .extMode(extMode),
    .enWe(enWe), .enData(enData), .prioWe(prioWe),
    .prio0Data(prio0Data), .prio1Data(prio1Data),
    .stb(stb), .reqQ(reqQ), .srcLvl(srcLvl)
  );

  irqgrp_control u_ctl (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe),
    .reqQ(reqQ), .srcLvl(srcLvl), .vecAck(vecAck), .retStrobe(retStrobe),
    .stb(stb), .vecValid(vecValid), .vecAddr(vecAddr)
  );
endmodule

// File: rtl/irq_group_arbiter_chk.sv
module irq_group_arbiter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        mcStrobe,
  input logic        vecAck,
  input logic        vecValid,
  input logic [15:0] vecAddr
);
  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && !vecAck |=> vecValid && $stable(vecAddr));

  p_ack_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && vecAck |=> !vecValid);

  p_issue_on_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vecValid) |-> $past(mcStrobe));

  p_vector_form_r1: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecAddr[2:0] == 3'b011) && (vecAddr <= 16'h009B));
endmodule

bind irq_group_arbiter irq_group_arbiter_chk u_chk (
  .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .vecAck(vecAck),
  .vecValid(vecValid), .vecAddr(vecAddr)
);

// File: tb/irq_group_arbiter_test.sv
module irq_group_arbiter_test;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0, rstN = 1'b0, mcStrobe = 1'b0;
  logic [6:0]  extPin = 7'b0000011;
  logic [9:0]  pFlag = '0;
  logic [3:0]  extMode = 4'b1111;
  logic        enWe = 1'b0, prioWe = 1'b0, vecAck = 1'b0, retStrobe = 1'b0;
  logic [14:0] enData = '0;
  logic [5:0]  p0d = '0, p1d = '0;
  logic        vecValid;
  logic [15:0] vecAddr;
  int checks = 0, errors = 0;

  irq_group_arbiter uut (
    .clk(clk), .rstN(rstN), .mcStrobe(mcStrobe), .extPin(extPin),
    .periphFlag(pFlag), .extMode(extMode), .enWe(enWe), .enData(enData),
    .prioWe(prioWe), .prio0Data(p0d), .prio1Data(p1d), .vecAck(vecAck),
    .retStrobe(retStrobe), .vecValid(vecValid), .vecAddr(vecAddr)
  );

  always #2.5 clk = ~clk;

  int sc = 0;
  always @(negedge clk) begin
    sc = (sc == 3) ? 0 : sc + 1;
    mcStrobe = (sc == 3);
  end

  // ---------------- behavioural reference ----------------
  bit [15:0] VT [14] = '{16'h03, 16'h0B, 16'h13, 16'h1B, 16'h23, 16'h2B, 16'h43,
                         16'h4B, 16'h53, 16'h5B, 16'h63, 16'h6B, 16'h83, 16'h9B};
  bit mSmp[14], mPrv[14], mFlag[14];
  bit [14:0] mEn;
  bit [5:0]  mP0, mP1;
  int mStack[$];
  bit mPollV, mV;
  int mPollI, mVI, mVL;
  bit [15:0] mVA;

  function automatic int grpOf(int s);
    case (s)
      0, 6: return 0;
      1, 7: return 1;
      2, 8: return 2;
      3, 9: return 3;
      4, 10, 12: return 4;
      default: return 5;
    endcase
  endfunction

  function automatic int lvlOf(int s);
    return 2 * mP1[grpOf(s)] + mP0[grpOf(s)];
  endfunction

  function automatic bit rawOf(int s);
    case (s)
      0: return extPin[0];
      1: return pFlag[0];
      2: return extPin[1];
      3: return pFlag[1];
      4: return pFlag[2] | pFlag[3];
      5: return pFlag[4] | pFlag[5];
      6: return pFlag[6];
      12: return pFlag[7] | pFlag[8];
      13: return pFlag[9];
      default: return extPin[s - 5];
    endcase
  endfunction

  task automatic modeOf(input int s, output bit e, output bit rise, output bit low);
    e = 0; rise = 0; low = 0;
    if (s == 0) begin e = extMode[0]; low = 1; end
    else if (s == 2) begin e = extMode[1]; low = 1; end
    else if (s == 7) begin e = 1; rise = extMode[2]; end
    else if (s == 8) begin e = 1; rise = extMode[3]; end
    else if (s >= 9 && s <= 11) begin e = 1; rise = 1; end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 14; s++) begin
        mSmp[s] = (s == 0 || s == 2); mPrv[s] = mSmp[s]; mFlag[s] = 0;
      end
      mEn = '0; mP0 = '0; mP1 = '0; mStack.delete();
      mPollV = 0; mPollI = 0; mV = 0; mVI = 0; mVL = 0; mVA = '0;
    end else begin
      bit r[14], el[14], setE[14], isE[14];
      int top, win, wl, oldPoll;
      bit found, issueNow, ackNow;
      top = (mStack.size() > 0) ? mStack[$] : -1;
      found = 0; win = 0; wl = -1;
      for (int s = 0; s < 14; s++) begin
        bit e, rise, low;
        modeOf(s, e, rise, low);
        isE[s] = e;
        r[s] = e ? mFlag[s] : (low ? !mPrv[s] : mPrv[s]);
        setE[s] = mcStrobe && e && (rise ? (!mPrv[s] && mSmp[s]) : (mPrv[s] && !mSmp[s]));
        el[s] = r[s] && mEn[s] && mEn[14] && (lvlOf(s) > top);
        if (el[s] && lvlOf(s) > wl) begin found = 1; win = s; wl = lvlOf(s); end
      end
      oldPoll  = mPollI;
      issueNow = mcStrobe && !mV && mPollV && el[oldPoll];
      ackNow   = mV && vecAck;
      for (int s = 0; s < 14; s++) begin
        if (setE[s]) mFlag[s] = 1;
        else if ((ackNow && mVI == s) || !isE[s]) mFlag[s] = 0;
      end
      if (mcStrobe) begin
        for (int s = 0; s < 14; s++) begin mPrv[s] = mSmp[s]; mSmp[s] = rawOf(s); end
        mPollV = found; mPollI = win;
      end
      if (retStrobe && mStack.size() > 0) void'(mStack.pop_back());
      if (ackNow) begin mV = 0; mStack.push_back(mVL); end
      if (issueNow) begin mV = 1; mVI = oldPoll; mVL = lvlOf(oldPoll); mVA = VT[oldPoll]; end
      if (enWe) mEn = enData;
      if (prioWe) begin mP0 = p0d; mP1 = p1d; end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (vecValid !== mV || (mV && vecAddr !== mVA)) begin
        errors++;
        $display("FAIL R7 model compare: valid %0b addr %h expected valid %0b addr %h",
                 vecValid, vecAddr, mV, mVA);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic waitStrobe();
    @(posedge clk);
    while (!mcStrobe) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitS(input int n);
    for (int k = 0; k < n; k++) waitStrobe();
  endtask

  task automatic expectVec(input string tag, input logic [15:0] exp);
    for (int k = 0; k < 10 && !vecValid; k++) waitStrobe();
    chk(vecValid === 1'b1 && vecAddr === exp, tag, vecValid ? vecAddr : 16'hFFFF, exp);
  endtask

  task automatic expectNone(input string tag, input int n);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin waitStrobe(); if (vecValid) seen = 1; end
    chk(!seen, tag, {15'd0, seen}, 16'h0);
  endtask

  task automatic ack();
    vecAck = 1; @(negedge clk); vecAck = 0;
  endtask

  task automatic ret();
    retStrobe = 1; @(negedge clk); retStrobe = 0;
  endtask

  task automatic wrEn(input logic [14:0] d);
    enWe = 1; enData = d; @(negedge clk); enWe = 0;
  endtask

  task automatic wrPrio(input logic [5:0] a, input logic [5:0] b);
    prioWe = 1; p0d = a; p1d = b; @(negedge clk); prioWe = 0;
  endtask

  task automatic setSrc(input int s, input bit on);
    case (s)
      0: extPin[0] = !on;
      2: extPin[1] = !on;
      1: pFlag[0] = on;
      3: pFlag[1] = on;
      4: pFlag[3] = on;
      5: pFlag[5] = on;
      6: pFlag[6] = on;
      12: pFlag[7] = on;
      13: pFlag[9] = on;
      default: extPin[s - 5] = on;
    endcase
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired actual 0 expected 1");
    finishRun();
  end

  initial begin
    repeat (10) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(vecValid === 1'b0, "R10 reset state", {15'd0, vecValid}, 16'h0);

    // R1 / R11: every source alone, vector table
    for (int s = 0; s < 14; s++) begin
      wrEn(15'h4000 | (15'd1 << s));
      setSrc(s, 1);
      expectVec($sformatf("R1 R11 vector of source %0d", s), VT[s]);
      ack();
      setSrc(s, 0);
      waitS(3);
      ret();
      expectNone($sformatf("R5 no repeat after ack, source %0d", s), 5);
    end

    // R9: latency in strobes
    wrEn(15'h4001);
    waitStrobe();
    extPin[0] = 0;
    for (int k = 1; k <= 3; k++) begin
      waitStrobe();
      chk(!vecValid, $sformatf("R9 quiet after strobe %0d", k), {15'd0, vecValid}, 16'h0);
    end
    waitStrobe();
    chk(vecValid && vecAddr == 16'h03, "R9 vector at fourth strobe", vecAddr, 16'h03);
    ack(); extPin[0] = 1; ret();

    // R4: low-level ext0 is not latched
    extMode = 4'b1110;
    extPin[0] = 0;
    expectVec("R4 low level ext0", 16'h03);
    ack(); ret();
    expectVec("R4 level re-request after return", 16'h03);
    ack(); extPin[0] = 1; waitS(3); ret();
    expectNone("R4 level released", 5);

    // R5: ext2 in falling mode ignores rising edge
    extMode = 4'b1010;
    wrEn(15'h4000 | (15'd1 << 7));
    extPin[2] = 1;
    expectNone("R5 rising edge ignored in falling mode", 6);
    extPin[2] = 0;
    expectVec("R5 falling edge on ext2", 16'h4B);
    ack(); ret();
    expectNone("R5 flag cleared by ack", 5);
    extMode = 4'b1111;

    // R2: disabled source
    wrEn(15'h4000 | (15'd1 << 1));
    pFlag[1] = 1;
    expectNone("R2 disabled source silent", 6);
    wrEn(15'h4000 | (15'd1 << 3));
    expectVec("R2 enabled source served", 16'h1B);
    ack(); pFlag[1] = 0; waitS(3); ret();

    // R3: global enable keeps pending flags
    wrEn(15'h3FFF);
    extPin[4] = 1; waitS(2); extPin[4] = 0;
    expectNone("R3 global disable masks", 6);
    wrEn(15'h7FFF);
    expectVec("R3 pending flag served after global enable", 16'h5B);
    ack(); ret();
    expectNone("R3 nothing left", 4);

    // R7 / R8: tie at level 0
    pFlag[0] = 1; pFlag[6] = 1;
    expectVec("R7 tie resolved to lowest vector", 16'h0B);
    ack();
    expectNone("R8 equal level does not preempt", 6);
    pFlag[0] = 0; waitS(3); ret();
    expectVec("R7 remaining request served", 16'h43);
    ack(); pFlag[6] = 0; waitS(3); ret();
    expectNone("R7 idle", 4);

    // R6: group 0 raised to level 1 via prio0
    wrPrio(6'b000001, 6'b000000);
    pFlag[0] = 1; pFlag[6] = 1;
    expectVec("R6 ADC group level 1 beats timer0", 16'h43);
    ack(); pFlag[6] = 0; waitS(3); ret();
    expectVec("R6 timer0 after ADC", 16'h0B);
    ack(); pFlag[0] = 0; waitS(3); ret();

    // R6: level 3 needs both bits
    wrPrio(6'b100000, 6'b110000);
    pFlag[8] = 1; pFlag[9] = 1;
    expectVec("R6 level 3 compare beats level 2 serial1", 16'h9B);
    ack(); pFlag[9] = 0; waitS(3); ret();
    expectVec("R11 serial1 transmit flag served", 16'h83);
    ack(); pFlag[8] = 0; waitS(3); ret();

    // R8: nesting
    wrPrio(6'b000010, 6'b001000);
    pFlag[0] = 1;
    expectVec("R8 level 1 timer0", 16'h0B);
    ack();
    pFlag[1] = 1;
    expectVec("R8 level 2 timer1 preempts", 16'h1B);
    ack(); pFlag[1] = 0; waitS(3); ret();
    expectNone("R8 return retires only the top level", 5);
    pFlag[0] = 0; waitS(3); ret();
    expectNone("R8 all retired", 4);

    finishRun();
  end
endmodule